// File: doc/BRIEF.md
# Lockable Analog Configuration Register Bank

This block holds the static configuration that steers a mixed-signal subsystem: the temperature sensor enable, the reference mode and 2.5 V select for two converter references, the low-supply brown-out disable, the source selects of the positive and negative comparator inputs, and the paths that feed the shared DAC output back into two ADCs. A word-addressed read/write bus reaches each register at a fixed offset. Every register bit drives a level output straight into the analog side.

Writes pass three separate gates. A protect-enable input must be high for every register except the loopback register. A set-once lock word can freeze individual registers until the next reset. The loopback register takes a write only when the upper half of the write data carries a fixed key. The registers sit in two reset domains: a system reset clears the sensor, monitor and lock registers, and a device reset clears everything else.

Top module: `anacfg_bank`

## Requirements
- R1: Mapped word offsets are 0x60 sensor, 0x68 reference, 0x70 monitor, 0x82 positive-high mux, 0x84 positive-low mux, 0x86 negative-high mux, 0x87 negative-low mux, 0x88 loopback, 0x8E lock. A read of any other offset returns 0 with bus_err high for that one response cycle. A write to any other offset changes nothing.
- R2: A write to any register except the loopback register is dropped when prot_en is low. The loopback register ignores prot_en.
- R3: Lock word bits are 0 sensor, 1 reference, 2 monitor, 5 positive-high mux, 6 positive-low mux, 7 negative-high mux, 8 negative-low mux, 9 a spare regulator lock. Writing 1 sets a bit and writing 0 leaves it. Only the system reset clears the lock word. Lock bits 3, 4 and 10 to 31 read 0.
- R4: While a register's lock bit is set, every write to that register is ignored.
- R5: A loopback write takes effect only when wdata[31:16] equals 0xA5A5. Bits 31:16 of the loopback register always read 0.
- R6: Loopback bit 0 drives adc_a_lb and bit 2 drives adc_c_lb. Each one forces that ADC to sample the DAC output. Bit 1 is stored and read back.
- R7: Each positive mux register holds four 3-bit selects at bits 2:0, 5:3, 8:6 and 11:9, for comparators 1 to 4, on cmp_*p_sel in the same positions. Each negative mux register holds four 1-bit selects at bits 3:0.
- R8: Reset values: reference register 0x0000_0007, meaning external reference on both sides and 2.5 V selects at bits 8 and 10 clear. Every other register resets to 0. The outputs follow: ref_ext_a is bit 0, ref_ext_c is bit 2, ref_2v5_a is bit 8, ref_2v5_c is bit 10, and vmon_bor_off is monitor bit 8.
- R9: sys_rst_n clears only the sensor, monitor and lock registers. dev_rst_n clears the reference, mux and loopback registers and bad_code.
- R10: Read-back masks: sensor 0x1, reference 0x707, monitor 0x103, positive mux 0x3F7FFF, negative mux 0x7F, loopback 0x7, lock 0x3E7. Reserved writable bits inside a mask keep what was written. Bits outside a mask read 0.
- R11: An accepted positive-mux write with any 3-bit select above 4 stores the code as written and sets bad_code. bad_code stays high until dev_rst_n.
- R12: bus_rdata carries the read value in the cycle after the read request. In any cycle after one with no read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| dev_rst_n | input | 1 | Device reset, active low, asynchronous |
| prot_en | input | 1 | Write permission for protected registers |
| bus_req | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Unmapped read response |
| tsense_en | output | 1 | Temperature sensor enable |
| ref_ext_a | output | 1 | Reference A external mode |
| ref_ext_c | output | 1 | Reference C external mode |
| ref_2v5_a | output | 1 | Reference A 2.5 V select |
| ref_2v5_c | output | 1 | Reference C 2.5 V select |
| vmon_bor_off | output | 1 | Low-supply brown-out disable |
| cmp_hp_sel | output | 12 | Positive-high mux selects |
| cmp_lp_sel | output | 12 | Positive-low mux selects |
| cmp_hn_sel | output | 4 | Negative-high mux selects |
| cmp_ln_sel | output | 4 | Negative-low mux selects |
| adc_a_lb | output | 1 | DAC loopback into ADC A |
| adc_c_lb | output | 1 | DAC loopback into ADC C |
| bad_code | output | 1 | Sticky reserved-select flag |

## Verification
The hardest state to reach is a split reset: lock bits set and a reserved mux code flagged, then only one reset domain pulsed. The surviving half has to keep its values while the other half returns to reset. The stimulus builds that state with a directed run: it sets locks, writes a code of 5 and loads the references, then pulses sys_rst_n and dev_rst_n in turn. After each pulse it reads back both sides. A long random phase then mixes keyed and unkeyed loopback writes, protect toggling, unmapped offsets and occasional lock writes, and a behavioural model follows every cycle.

// File: rtl/anacfg_pkg.sv
package anacfg_pkg;
  localparam int DW      = 32;
  localparam int NREG    = 9;
  localparam int CMP_N   = 4;
  localparam int SEL_W   = 3;
  localparam int SEL_MAX = 4;
  localparam int KEY_W   = 16;
  localparam int LK_W    = 5;

  localparam int IX_TEMP = 0;
  localparam int IX_REF  = 1;
  localparam int IX_VMON = 2;
  localparam int IX_HP   = 3;
  localparam int IX_LP   = 4;
  localparam int IX_HN   = 5;
  localparam int IX_LN   = 6;
  localparam int IX_LB   = 7;
  localparam int IX_LOCK = 8;

  localparam logic [7:0] REG_OFS [NREG] =
    '{8'h60, 8'h68, 8'h70, 8'h82, 8'h84, 8'h86, 8'h87, 8'h88, 8'h8E};
  localparam logic [DW-1:0] REG_MASK [NREG] =
    '{32'h1, 32'h707, 32'h103, 32'h3F7FFF, 32'h3F7FFF, 32'h7F, 32'h7F, 32'h7, 32'h3E7};
  localparam logic [DW-1:0] REG_RSTV [NREG] =
    '{32'h0, 32'h7, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  // 1: system reset domain, 0: device reset domain
  localparam bit REG_SYS [NREG] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam bit REG_LOCKABLE [NREG] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [LK_W-1:0] REG_LOCKPOS [NREG] =
    '{5'd0, 5'd1, 5'd2, 5'd5, 5'd6, 5'd7, 5'd8, 5'd0, 5'd0};

  // any 3-bit select above the last valid code
  function automatic logic sel_code_bad(input logic [CMP_N*SEL_W-1:0] f);
    logic b;
    b = 1'b0;
    for (int k = 0; k < CMP_N; k++)
      if (int'(f[k*SEL_W +: SEL_W]) > SEL_MAX) b = 1'b1;
    return b;
  endfunction

  function automatic logic key_match(input logic [DW-1:0] w, input logic [KEY_W-1:0] k);
    return w[DW-1 -: KEY_W] == k;
  endfunction
endpackage

// File: rtl/anacfg_reg.sv
module anacfg_reg #(
  parameter int          W      = 32,
  parameter logic [W-1:0] MASK  = {W{1'b1}},
  parameter logic [W-1:0] RSTV  = '0,
  parameter bit          STICKY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  if (STICKY) begin : g_setonce
    assign nxt = q | (wdata & MASK);
  end else begin : g_plain
    assign nxt = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RSTV & MASK;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/anacfg_decode.sv
module anacfg_decode import anacfg_pkg::*; #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] sel,
  output logic            hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign sel[g] = (addr == AW'(REG_OFS[g]));
  end
  assign hit = |sel;
endmodule

// File: rtl/anacfg_bank.sv
module anacfg_bank import anacfg_pkg::*; #(
  parameter int               AW   = 8,
  parameter logic [KEY_W-1:0] WKEY = 16'hA5A5
) (
  input  logic                   clk,
  input  logic                   sys_rst_n,
  input  logic                   dev_rst_n,
  input  logic                   prot_en,
  input  logic                   bus_req,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic                   bus_err,
  output logic                   tsense_en,
  output logic                   ref_ext_a,
  output logic                   ref_ext_c,
  output logic                   ref_2v5_a,
  output logic                   ref_2v5_c,
  output logic                   vmon_bor_off,
  output logic [CMP_N*SEL_W-1:0] cmp_hp_sel,
  output logic [CMP_N*SEL_W-1:0] cmp_lp_sel,
  output logic [CMP_N-1:0]       cmp_hn_sel,
  output logic [CMP_N-1:0]       cmp_ln_sel,
  output logic                   adc_a_lb,
  output logic                   adc_c_lb,
  output logic                   bad_code
);
  localparam int SELS_W = CMP_N * SEL_W;

  logic [NREG-1:0] sel, gate, we;
  logic            hit;
  logic [DW-1:0]   q [NREG];
  logic [DW-1:0]   lock_vec;
  logic [DW-1:0]   rd_val;
  logic [DW-1:0]   rdata_q;
  logic            err_q, bad_q;

  // named events
  logic wr_req, rd_req, wr_drop, rd_miss, bad_set;

  assign wr_req = bus_req & bus_wr;
  assign rd_req = bus_req & ~bus_wr;

  anacfg_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit)
  );

  assign lock_vec = q[IX_LOCK];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      if (i == IX_LB)           gate[i] = key_match(bus_wdata, WKEY);
      else if (REG_LOCKABLE[i]) gate[i] = prot_en & ~lock_vec[REG_LOCKPOS[i]];
      else                      gate[i] = prot_en;
    end
  end

  assign we      = sel & gate & {NREG{wr_req}};
  assign wr_drop = wr_req & hit & ~(|we);
  assign rd_miss = rd_req & ~hit;
  assign bad_set = (we[IX_HP] & sel_code_bad(bus_wdata[SELS_W-1:0]))
                 | (we[IX_LP] & sel_code_bad(bus_wdata[SELS_W-1:0]));

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    anacfg_reg #(
      .W      (DW),
      .MASK   (REG_MASK[g]),
      .RSTV   (REG_RSTV[g]),
      .STICKY (g == IX_LOCK)
    ) u_r (
      .clk   (clk),
      .rst_n (REG_SYS[g] ? sys_rst_n : dev_rst_n),
      .we    (we[g]),
      .wdata (bus_wdata),
      .q     (q[g])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rd_val = rd_val | q[i];
  end

  always_ff @(posedge clk or negedge dev_rst_n) begin
    if (!dev_rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      rdata_q <= rd_req ? rd_val : '0;
      err_q   <= rd_miss;
      if (bad_set) bad_q <= 1'b1;
    end
  end

  assign bus_rdata    = rdata_q;
  assign bus_err      = err_q;
  assign bad_code     = bad_q;
  assign tsense_en    = q[IX_TEMP][0];
  assign ref_ext_a    = q[IX_REF][0];
  assign ref_ext_c    = q[IX_REF][2];
  assign ref_2v5_a    = q[IX_REF][8];
  assign ref_2v5_c    = q[IX_REF][10];
  assign vmon_bor_off = q[IX_VMON][8];
  assign cmp_hp_sel   = q[IX_HP][SELS_W-1:0];
  assign cmp_lp_sel   = q[IX_LP][SELS_W-1:0];
  assign cmp_hn_sel   = q[IX_HN][CMP_N-1:0];
  assign cmp_ln_sel   = q[IX_LN][CMP_N-1:0];
  assign adc_a_lb     = q[IX_LB][0];
  assign adc_c_lb     = q[IX_LB][2];
endmodule

// File: rtl/anacfg_chk.sv
module anacfg_chk import anacfg_pkg::*; #(
  parameter int AW    = 8,
  parameter int CFG_W = 38
) (
  input logic             clk,
  input logic             sys_rst_n,
  input logic             dev_rst_n,
  input logic             prot_en,
  input logic             bus_req,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_err,
  input logic             tsense_en,
  input logic             adc_a_lb,
  input logic             adc_c_lb,
  input logic             bad_code,
  input logic [DW-1:0]    lock_vec,
  input logic [CFG_W-1:0] cfg_vec
);
  logic lb_badkey_wr;
  assign lb_badkey_wr = bus_req && bus_wr && (bus_addr == AW'(REG_OFS[IX_LB]))
                     && (bus_wdata[DW-1 -: KEY_W] != 16'hA5A5);

  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    bus_err |-> bus_rdata == '0);
  // R1
  miss_cause_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    bus_err |-> $past(bus_req && !bus_wr));
  // R2
  prot_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    (bus_req && bus_wr && !prot_en) |=> $stable(cfg_vec));
  // R3
  lock_keep_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));
  // R4
  temp_lock_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    lock_vec[0] |=> $stable(tsense_en));
  // R5
  key_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    lb_badkey_wr |=> $stable({adc_a_lb, adc_c_lb}));
  // R11
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    bad_code |=> bad_code);
  // R12
  rd_idle_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !dev_rst_n)
    !(bus_req && !bus_wr) |=> bus_rdata == '0);
endmodule

bind anacfg_bank anacfg_chk #(.AW(AW), .CFG_W(38)) u_chk (
  .clk       (clk),
  .sys_rst_n (sys_rst_n),
  .dev_rst_n (dev_rst_n),
  .prot_en   (prot_en),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .tsense_en (tsense_en),
  .adc_a_lb  (adc_a_lb),
  .adc_c_lb  (adc_c_lb),
  .bad_code  (bad_code),
  .lock_vec  (lock_vec),
  .cfg_vec   ({tsense_en, ref_ext_a, ref_ext_c, ref_2v5_a, ref_2v5_c, vmon_bor_off,
                cmp_hp_sel, cmp_lp_sel, cmp_hn_sel, cmp_ln_sel})
);

// File: tb/tb_anacfg_bank.sv
`timescale 1ns/1ps
module tb_anacfg_bank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic sys_rst_n, dev_rst_n, prot_en, bus_req, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_err, tsense_en, ref_ext_a, ref_ext_c, ref_2v5_a, ref_2v5_c, vmon_bor_off;
  logic [11:0] cmp_hp_sel, cmp_lp_sel;
  logic [3:0]  cmp_hn_sel, cmp_ln_sel;
  logic adc_a_lb, adc_c_lb, bad_code;

  anacfg_bank dut (.*);

  int total = 0, nbad = 0;
  bit done = 0, live = 0;
  logic [31:0] r_data;
  logic        r_err;

  // behavioural reference state
  logic [31:0] m_temp, m_ref, m_vmon, m_hp, m_lp, m_hn, m_ln, m_lb, m_lock, m_rd, t_rv;
  logic m_bad, m_err, t_map;

  function automatic bit has_bad_sel(input logic [31:0] w);
    for (int k = 0; k < 4; k++) if (((w >> (3*k)) & 32'h7) > 4) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    t_map = 1;
    case (bus_addr)
      8'h60: t_rv = m_temp;  8'h68: t_rv = m_ref;  8'h70: t_rv = m_vmon;
      8'h82: t_rv = m_hp;    8'h84: t_rv = m_lp;   8'h86: t_rv = m_hn;
      8'h87: t_rv = m_ln;    8'h88: t_rv = m_lb;   8'h8E: t_rv = m_lock;
      default: begin t_rv = 0; t_map = 0; end
    endcase
    if (!dev_rst_n) begin
      m_ref = 32'h7; m_hp = 0; m_lp = 0; m_hn = 0; m_ln = 0; m_lb = 0;
      m_bad = 0; m_rd = 0; m_err = 0;
    end else begin
      m_rd  = (bus_req && !bus_wr) ? t_rv : 32'h0;
      m_err = bus_req && !bus_wr && !t_map;
      if (bus_req && bus_wr) case (bus_addr)
        8'h68: if (prot_en && !m_lock[1]) m_ref = bus_wdata & 32'h707;
        8'h82: if (prot_en && !m_lock[5]) begin
                 m_hp = bus_wdata & 32'h3F7FFF; if (has_bad_sel(bus_wdata)) m_bad = 1; end
        8'h84: if (prot_en && !m_lock[6]) begin
                 m_lp = bus_wdata & 32'h3F7FFF; if (has_bad_sel(bus_wdata)) m_bad = 1; end
        8'h86: if (prot_en && !m_lock[7]) m_hn = bus_wdata & 32'h7F;
        8'h87: if (prot_en && !m_lock[8]) m_ln = bus_wdata & 32'h7F;
        8'h88: if (bus_wdata[31:16] == 16'hA5A5) m_lb = bus_wdata & 32'h7;
        default: ;
      endcase
    end
    if (!sys_rst_n) begin
      m_temp = 0; m_vmon = 0; m_lock = 0;
    end else if (bus_req && bus_wr && prot_en) case (bus_addr)
      8'h60: if (!m_lock[0]) m_temp = bus_wdata & 32'h1;
      8'h70: if (!m_lock[2]) m_vmon = bus_wdata & 32'h103;
      8'h8E: m_lock = m_lock | (bus_wdata & 32'h3E7);
      default: ;
    endcase
  end

  always @(negedge clk) begin
    if (live && sys_rst_n && dev_rst_n) begin
      check("R2 tsense_en", {31'b0, tsense_en}, {31'b0, m_temp[0]});
      check("R8 ref outputs", {28'b0, ref_2v5_c, ref_2v5_a, ref_ext_c, ref_ext_a},
            {28'b0, m_ref[10], m_ref[8], m_ref[2], m_ref[0]});
      check("R10 vmon_bor_off", {31'b0, vmon_bor_off}, {31'b0, m_vmon[8]});
      check("R7 mux selects", {cmp_hp_sel, cmp_lp_sel, cmp_hn_sel, cmp_ln_sel},
            {m_hp[11:0], m_lp[11:0], m_hn[3:0], m_ln[3:0]});
      check("R6 loopback", {30'b0, adc_c_lb, adc_a_lb}, {30'b0, m_lb[2], m_lb[0]});
      check("R11 bad_code", {31'b0, bad_code}, {31'b0, m_bad});
      check("R12 bus_rdata", bus_rdata, m_rd);
      check("R1 bus_err", {31'b0, bus_err}, {31'b0, m_err});
    end
  end

  task automatic wop(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rop(input logic [7:0] a);
    bus_req = 1; bus_wr = 0; bus_addr = a; bus_wdata = $urandom;
    @(posedge clk); #1;
    bus_req = 0;
    r_data = bus_rdata; r_err = bus_err;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [12];
    alist = '{8'h60, 8'h68, 8'h70, 8'h82, 8'h84, 8'h86, 8'h87, 8'h88, 8'h8E, 8'h61, 8'h00, 8'h8F};
    sys_rst_n = 0; dev_rst_n = 0; prot_en = 0; bus_req = 0; bus_wr = 0;
    bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk); #1;
    sys_rst_n = 1; dev_rst_n = 1; live = 1;

    // R8 reset state
    rop(8'h68); check("R8 ref reset", r_data, 32'h7);
    rop(8'h60); check("R8 temp reset", r_data, 32'h0);
    check("R8 bad_code reset", {31'b0, bad_code}, 32'h0);
    // R2 protect
    wop(8'h60, 32'h1); check("R2 dropped write", {31'b0, tsense_en}, 32'h0);
    prot_en = 1;
    wop(8'h60, 32'h1); check("R2 allowed write", {31'b0, tsense_en}, 32'h1);
    // R10 masks
    wop(8'h68, 32'hFFFF_FFFF); rop(8'h68); check("R10 ref mask", r_data, 32'h707);
    check("R8 ref_2v5_c", {31'b0, ref_2v5_c}, 32'h1);
    wop(8'h70, 32'hFFFF_FFFF); rop(8'h70); check("R10 vmon mask", r_data, 32'h103);
    // R7 field layout
    wop(8'h82, 32'h8D1); check("R7 hp fields", {20'b0, cmp_hp_sel}, 32'h8D1);
    check("R11 valid codes", {31'b0, bad_code}, 32'h0);
    wop(8'h84, 32'h5); check("R11 code 5 flags", {31'b0, bad_code}, 32'h1);
    rop(8'h84); check("R11 code kept", r_data, 32'h5);
    wop(8'h86, 32'hFF); rop(8'h86); check("R10 hn mask", r_data, 32'h7F);
    check("R7 hn fields", {28'b0, cmp_hn_sel}, 32'hF);
    // R5 and R6 loopback key
    prot_en = 0;
    wop(8'h88, 32'h1234_0005); check("R5 wrong key", {30'b0, adc_c_lb, adc_a_lb}, 32'h0);
    wop(8'h88, 32'hA5A5_0005); check("R6 keyed write", {30'b0, adc_c_lb, adc_a_lb}, 32'h3);
    rop(8'h88); check("R5 key reads 0", r_data, 32'h5);
    prot_en = 1;
    // R1 unmapped
    rop(8'h61); check("R1 miss data", r_data, 32'h0); check("R1 miss err", {31'b0, r_err}, 32'h1);
    idle(); check("R1 err one cycle", {31'b0, bus_err}, 32'h0);
    wop(8'h61, 32'hFFFF_FFFF); rop(8'h60); check("R1 miss write ignored", r_data, 32'h1);
    idle(); check("R12 idle rdata", bus_rdata, 32'h0);
    // R3 and R4 locks
    wop(8'h8E, 32'h1); rop(8'h8E); check("R3 lock set", r_data, 32'h1);
    wop(8'h60, 32'h0); check("R4 locked temp", {31'b0, tsense_en}, 32'h1);
    wop(8'h8E, 32'h0); rop(8'h8E); check("R3 zero no effect", r_data, 32'h1);
    wop(8'h8E, 32'hFFFF_FFFF); rop(8'h8E); check("R3 lock mask", r_data, 32'h3E7);
    wop(8'h82, 32'h0); check("R4 locked mux", {20'b0, cmp_hp_sel}, 32'h8D1);
    // R9 system reset only
    sys_rst_n = 0; idle(); sys_rst_n = 1;
    check("R9 temp cleared", {31'b0, tsense_en}, 32'h0);
    rop(8'h8E); check("R9 lock cleared", r_data, 32'h0);
    rop(8'h68); check("R9 ref kept", r_data, 32'h707);
    check("R9 hp kept", {20'b0, cmp_hp_sel}, 32'h8D1);
    check("R9 flag kept", {31'b0, bad_code}, 32'h1);
    // R9 device reset only
    wop(8'h60, 32'h1);
    dev_rst_n = 0; idle(); dev_rst_n = 1;
    rop(8'h68); check("R9 ref reset", r_data, 32'h7);
    check("R9 hp reset", {20'b0, cmp_hp_sel}, 32'h0);
    check("R9 lb reset", {30'b0, adc_c_lb, adc_a_lb}, 32'h0);
    check("R9 flag reset", {31'b0, bad_code}, 32'h0);
    check("R9 temp kept", {31'b0, tsense_en}, 32'h1);

    // random phase, checked against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = alist[$urandom_range(0, 11)];
      d = $urandom;
      prot_en = ($urandom_range(0, 3) != 0);
      if (a == 8'h88 && $urandom_range(0, 1) == 1) d[31:16] = 16'hA5A5;
      if (a == 8'h8E && $urandom_range(0, 19) != 0) a = 8'h82;
      if (a == 8'h8E) d = d & 32'h0000_0333;
      case ($urandom_range(0, 2))
        0: wop(a, d);
        1: rop(a);
        default: idle();
      endcase
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end
endmodule